// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Large Pages

This block keeps a small, fully associative set of recent virtual-to-physical page translations for a processor's memory pipeline. Every entry carries the identifier of the process that owns it. A lookup only hits when that identifier matches, so translations from several processes can sit side by side and survive a context switch with no flush. An entry maps either an ordinary page or a large page: an aligned, contiguous run of 2^SUPER_W ordinary pages. A large-page entry compares fewer page-number bits, and the bits it does not translate pass through into the physical address.

A lookup presents a virtual address, the current process identifier and a load/store flag. In the same cycle the block answers with hit, physical address, a permission fault and the entry's modified bit, or it raises miss to ask for a table walk. The walk result comes back through the fill port. The invalidate port removes a single translation, selected by process and page, or clears every entry at once. It is used when page permissions change or when another core requests a shootdown.

Top module: `ptag_tlb`

## Requirements
- R1: A synchronous reset clears every entry's valid bit, so any lookup in the first cycle after reset misses.
- R2: A lookup hits only on an entry that is valid, whose process tag equals `lk_pid` and whose page number matches. The same page under another process tag misses.
- R3: For an ordinary page hit, `lk_pa` is the entry's frame number followed by the low PAGE_OFF_W bits of `lk_va`.
- R4: A large-page entry compares only the upper VPN_W-SUPER_W page bits. `lk_pa` then takes the upper PFN_W-SUPER_W frame bits followed by the low SUPER_W+PAGE_OFF_W bits of `lk_va`. An address one byte past the large page misses.
- R5: `lk_miss` equals `lk_valid` with no matching entry. `lk_hit` and `lk_miss` are never high together, and both are low while `lk_valid` is low.
- R6: A fill writes the lowest-index invalid entry. When every entry is valid, it writes the entry named by a replacement pointer. The pointer starts at entry 0 after reset and advances by one (wrapping) only on fills that use it.
- R7: A store (`lk_store`=1) that hits an entry without write permission raises `lk_fault` and leaves the modified bit clear. A load from such an entry does not fault.
- R8: A store that hits a writable entry sets that entry's modified bit from the next cycle on. On a hit, `lk_dirty` reports the entry's current modified bit, including the value loaded by a fill.
- R9: A single invalidate removes every entry with a matching process tag that covers `inv_page` under the rules of R2 and R4. Entries of other processes remain usable.
- R10: An invalidate with `inv_all` high removes every entry.
- R11: Lookup results are combinational in the lookup cycle. An invalidate or fill in that same cycle affects lookups only from the next cycle on.
- R12: When several entries match, the lowest-index entry supplies the frame, the rights and the modified bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pid | input | PID_W | Current process identifier |
| lk_va | input | VA_W | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation; table walk needed |
| lk_fault | output | 1 | Store to a read-only translation |
| lk_dirty | output | 1 | Modified bit of the hit entry |
| lk_pa | output | PA_W | Translated physical address |
| fill_en | input | 1 | Load a new entry this cycle |
| fill_pid | input | PID_W | Process tag of the new entry |
| fill_vpn | input | VA_W-PAGE_OFF_W | Virtual page number of the new entry |
| fill_pfn | input | PA_W-PAGE_OFF_W | Frame number of the new entry |
| fill_writable | input | 1 | 1 = read/write, 0 = read-only |
| fill_dirty | input | 1 | Initial modified bit |
| fill_super | input | 1 | Entry maps a large page |
| inv_en | input | 1 | Invalidate request this cycle |
| inv_all | input | 1 | Invalidate every entry |
| inv_pid | input | PID_W | Process tag to invalidate |
| inv_page | input | VA_W-PAGE_OFF_W | Page number to invalidate |

## Verification
Lookups are tried with the same page under two process tags, which separates a tag-qualified match from a page-only match. Addresses at the inner edge of a large page and one byte past its end show whether the masked compare and the pass-through offset use the right bit boundary. Overlapping large and ordinary entries, removed one at a time, show which entry wins a multiple match. A full array followed by fills mixed with a single invalidate tells the free-entry choice apart from round-robin replacement. Stores to read-only and writable entries, each followed by a load, show whether a fault is kept separate from the modified-bit update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_ENTRIES_DEF = 16;
  localparam int unsigned TLB_PID_W_DEF   = 8;
  localparam int unsigned TLB_VA_W_DEF    = 32;
  localparam int unsigned TLB_PA_W_DEF    = 32;
  localparam int unsigned TLB_OFF_W_DEF   = 12;
  localparam int unsigned TLB_SUPER_W_DEF = 10;

  typedef enum logic {
    PERM_RO = 1'b0,
    PERM_RW = 1'b1
  } perm_e;
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int unsigned PID_W   = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned SUPER_W = 10
) (
  input  logic             ent_vld,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic             ent_sup,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             match
);
  logic hi_eq, lo_eq, pid_eq;

  always_comb begin
    pid_eq = (ent_pid == req_pid);
    hi_eq  = (ent_vpn[VPN_W-1:SUPER_W] == req_vpn[VPN_W-1:SUPER_W]);
    lo_eq  = (ent_vpn[SUPER_W-1:0] == req_vpn[SUPER_W-1:0]);
    match  = ent_vld && pid_eq && hi_eq && (ent_sup || lo_eq);
  end
endmodule

// File: rtl/tlb_first_pick.sv
module tlb_first_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [N-1:0]     vld,
  output logic [IDX_W-1:0] victim
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_ptr;

  tlb_first_pick #(.N(N), .IDX_W(IDX_W)) u_free (
    .req (~vld),
    .any (free_any),
    .idx (free_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (fill_en && !free_any) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  assign victim = free_any ? free_idx : rr_ptr;
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES_DEF,
  parameter int unsigned PID_W   = TLB_PID_W_DEF,
  parameter int unsigned VA_W    = TLB_VA_W_DEF,
  parameter int unsigned PA_W    = TLB_PA_W_DEF,
  parameter int unsigned OFF_W   = TLB_OFF_W_DEF,
  parameter int unsigned SUPER_W = TLB_SUPER_W_DEF,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PFN_W  = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic             lk_dirty,
  output logic [PA_W-1:0]  lk_pa,
  input  logic             fill_en,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_writable,
  input  logic             fill_dirty,
  input  logic             fill_super,
  input  logic             inv_en,
  input  logic             inv_all,
  input  logic [PID_W-1:0] inv_pid,
  input  logic [VPN_W-1:0] inv_page
);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned SP_LOW = SUPER_W + OFF_W;
  localparam logic [PA_W-1:0] SP_MASK = PA_W'((64'd1 << SP_LOW) - 64'd1);

  logic [ENTRIES-1:0] ent_vld;
  logic [PID_W-1:0]   ent_pid   [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn   [ENTRIES];
  perm_e              ent_perm  [ENTRIES];
  logic               ent_dirty [ENTRIES];
  logic               ent_sup   [ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_match;
  logic [ENTRIES-1:0] inv_kill;
  logic               any_match;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  logic [VPN_W-1:0]   lk_vpn;
  logic               dirty_upd;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_tag_cmp #(.PID_W(PID_W), .VPN_W(VPN_W), .SUPER_W(SUPER_W)) u_lk_cmp (
      .ent_vld (ent_vld[g]),
      .ent_pid (ent_pid[g]),
      .ent_vpn (ent_vpn[g]),
      .ent_sup (ent_sup[g]),
      .req_pid (lk_pid),
      .req_vpn (lk_vpn),
      .match   (lk_match[g])
    );
    tlb_tag_cmp #(.PID_W(PID_W), .VPN_W(VPN_W), .SUPER_W(SUPER_W)) u_inv_cmp (
      .ent_vld (ent_vld[g]),
      .ent_pid (ent_pid[g]),
      .ent_vpn (ent_vpn[g]),
      .ent_sup (ent_sup[g]),
      .req_pid (inv_pid),
      .req_vpn (inv_page),
      .match   (inv_match[g])
    );
    assign inv_kill[g] = inv_en && (inv_all || inv_match[g]);
  end

  tlb_first_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_pick (
    .req (lk_match),
    .any (any_match),
    .idx (hit_idx)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .fill_en (fill_en),
    .vld     (ent_vld),
    .victim  (victim)
  );

  // Lookup result: same-cycle answer from the current array state.
  always_comb begin
    logic [PA_W-1:0] pa_page;
    logic [PA_W-1:0] pa_pass;
    pa_page  = {ent_pfn[hit_idx], lk_va[OFF_W-1:0]};
    pa_pass  = PA_W'(lk_va[SP_LOW-1:0]);
    lk_hit   = lk_valid && any_match;
    lk_miss  = lk_valid && !any_match;
    lk_fault = lk_hit && lk_store && (ent_perm[hit_idx] == PERM_RO);
    lk_dirty = lk_hit && ent_dirty[hit_idx];
    lk_pa    = ent_sup[hit_idx] ? ((pa_page & ~SP_MASK) | (pa_pass & SP_MASK)) : pa_page;
  end

  assign dirty_upd = lk_hit && lk_store && !lk_fault;

  // Array update: invalidate, then store marking, then fill (later wins).
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_kill[i]) ent_vld[i] <= 1'b0;
      end
      if (dirty_upd) ent_dirty[hit_idx] <= 1'b1;
      if (fill_en) begin
        ent_vld[victim]   <= 1'b1;
        ent_pid[victim]   <= fill_pid;
        ent_vpn[victim]   <= fill_vpn;
        ent_pfn[victim]   <= fill_pfn;
        ent_perm[victim]  <= fill_writable ? PERM_RW : PERM_RO;
        ent_dirty[victim] <= fill_dirty;
        ent_sup[victim]   <= fill_super;
      end
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int unsigned PID_W = 8,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [PID_W-1:0] lk_pid,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_store,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic             lk_dirty,
  input logic [PA_W-1:0]  lk_pa,
  input logic             fill_en,
  input logic             inv_en,
  input logic             inv_all
);
  logic unused_pa;
  assign unused_pa = ^lk_pa;

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lk_valid) |-> !lk_hit);

  assert_hit_miss_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_miss));

  assert_fault_on_store_hit_R7: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_hit && lk_store));

  assert_store_marks_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(lk_valid && lk_store && lk_hit && !lk_fault && !inv_en && !fill_en)
     && lk_valid && $stable(lk_va) && $stable(lk_pid)) |-> (lk_hit && lk_dirty));

  assert_flush_all_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_en && inv_all && !fill_en) && lk_valid) |-> !lk_hit);
endmodule

bind ptag_tlb tlb_chk #(.PID_W(PID_W), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .lk_pid   (lk_pid),
  .lk_va    (lk_va),
  .lk_store (lk_store),
  .lk_hit   (lk_hit),
  .lk_miss  (lk_miss),
  .lk_fault (lk_fault),
  .lk_dirty (lk_dirty),
  .lk_pa    (lk_pa),
  .fill_en  (fill_en),
  .inv_en   (inv_en),
  .inv_all  (inv_all)
);

// File: tb/sim_ptag_tlb.sv
`timescale 1ns/1ps
module sim_ptag_tlb;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_store;
  logic [7:0]  lk_pid;
  logic [31:0] lk_va;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [31:0] lk_pa;
  logic        fill_en, fill_writable, fill_dirty, fill_super;
  logic [7:0]  fill_pid;
  logic [19:0] fill_vpn, fill_pfn;
  logic        inv_en, inv_all;
  logic [7:0]  inv_pid;
  logic [19:0] inv_page;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ptag_tlb u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_va(lk_va),
    .lk_store(lk_store), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_dirty(lk_dirty), .lk_pa(lk_pa), .fill_en(fill_en), .fill_pid(fill_pid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_writable(fill_writable),
    .fill_dirty(fill_dirty), .fill_super(fill_super), .inv_en(inv_en),
    .inv_all(inv_all), .inv_pid(inv_pid), .inv_page(inv_page)
  );

  typedef struct packed {
    logic [7:0]  pid;
    logic [31:0] va;
    logic        st;
    logic        hit;
    logic        fault;
    logic [31:0] pa;
    logic        dirty;
  } vec_t;

  // Lookups against: pid1 p0x10->0xA00 rw, pid2 p0x10->0xB00 ro,
  // pid1 large 0x40000->0x80000 rw, pid1 p0x20->0xC00 ro.
  localparam vec_t VEC [9] = '{
    '{8'h01, 32'h00010123, 1'b0, 1'b1, 1'b0, 32'h00A00123, 1'b0},
    '{8'h02, 32'h00010456, 1'b0, 1'b1, 1'b0, 32'h00B00456, 1'b0},
    '{8'h03, 32'h00010000, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0},
    '{8'h01, 32'h40123ABC, 1'b0, 1'b1, 1'b0, 32'h80123ABC, 1'b0},
    '{8'h01, 32'h403FFFFF, 1'b0, 1'b1, 1'b0, 32'h803FFFFF, 1'b0},
    '{8'h01, 32'h40400000, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0},
    '{8'h02, 32'h40000000, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0},
    '{8'h02, 32'h00010000, 1'b1, 1'b1, 1'b1, 32'h00B00000, 1'b0},
    '{8'h01, 32'h00020000, 1'b0, 1'b1, 1'b0, 32'h00C00000, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; lk_valid = 0; lk_store = 0; lk_pid = 0; lk_va = 0;
    fill_en = 0; fill_pid = 0; fill_vpn = 0; fill_pfn = 0;
    fill_writable = 0; fill_dirty = 0; fill_super = 0;
    inv_en = 0; inv_all = 0; inv_pid = 0; inv_page = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(input logic [7:0] pid, input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic wr, input logic dty, input logic sup);
    fill_pid = pid; fill_vpn = vpn; fill_pfn = pfn;
    fill_writable = wr; fill_dirty = dty; fill_super = sup; fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic inval(input logic [7:0] pid, input logic [19:0] page, input logic all);
    inv_pid = pid; inv_page = page; inv_all = all; inv_en = 1'b1;
    @(negedge clk);
    inv_en = 1'b0; inv_all = 1'b0;
  endtask

  task automatic probe(input string req, input logic [7:0] pid, input logic [31:0] va,
                       input logic st, input logic ehit, input logic efault,
                       input logic [31:0] epa, input logic edirty);
    lk_pid = pid; lk_va = va; lk_store = st; lk_valid = 1'b1;
    #5;
    chk(req, "hit", lk_hit, ehit);
    chk(req, "miss", lk_miss, !ehit);
    chk(req, "fault", lk_fault, efault);
    chk(req, "dirty", lk_dirty, edirty);
    if (ehit) chk(req, "pa", lk_pa, epa);
    @(negedge clk);
    lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R5 idle outputs quiet, R1 empty after reset
    #5;
    chk("R5", "idle hit", lk_hit, 1'b0);
    chk("R5", "idle miss", lk_miss, 1'b0);
    @(negedge clk);
    probe("R1", 8'h01, 32'h00010123, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);

    fill(8'h01, 20'h00010, 20'h00A00, 1'b1, 1'b0, 1'b0);
    fill(8'h02, 20'h00010, 20'h00B00, 1'b0, 1'b0, 1'b0);
    fill(8'h01, 20'h40000, 20'h80000, 1'b1, 1'b0, 1'b1);
    fill(8'h01, 20'h00020, 20'h00C00, 1'b0, 1'b0, 1'b0);
    // Vector walk covers R2, R3, R4, R5, R7
    for (int i = 0; i < 9; i++) begin
      probe($sformatf("R2_R3_R4_R7 vec%0d", i), VEC[i].pid, VEC[i].va, VEC[i].st,
            VEC[i].hit, VEC[i].fault, VEC[i].pa, VEC[i].dirty);
    end

    // R7: faulting store left the modified bit clear
    probe("R7", 8'h02, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'h00B00000, 1'b0);
    // R8: store sets modified bit, seen next cycle
    fill(8'h01, 20'h00030, 20'h00D00, 1'b1, 1'b0, 1'b0);
    probe("R8", 8'h01, 32'h00030004, 1'b1, 1'b1, 1'b0, 32'h00D00004, 1'b0);
    probe("R8", 8'h01, 32'h00030004, 1'b0, 1'b1, 1'b0, 32'h00D00004, 1'b1);
    fill(8'h01, 20'h00040, 20'h00E00, 1'b1, 1'b1, 1'b0);
    probe("R8", 8'h01, 32'h00040008, 1'b0, 1'b1, 1'b0, 32'h00E00008, 1'b1);

    // R11: invalidate in the lookup cycle does not affect that lookup
    inv_pid = 8'h01; inv_page = 20'h00010; inv_all = 1'b0; inv_en = 1'b1;
    probe("R11", 8'h01, 32'h00010123, 1'b0, 1'b1, 1'b0, 32'h00A00123, 1'b0);
    inv_en = 1'b0;
    probe("R11", 8'h01, 32'h00010123, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    // R9: other process keeps its entry
    probe("R9", 8'h02, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'h00B00000, 1'b0);
    // R9: large page removed by an inner address
    inval(8'h01, 20'h40200, 1'b0);
    probe("R9", 8'h01, 32'h40123ABC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    probe("R9", 8'h01, 32'h00020000, 1'b0, 1'b1, 1'b0, 32'h00C00000, 1'b0);
    // R10: invalidate all
    inval(8'h00, 20'h0, 1'b1);
    probe("R10", 8'h02, 32'h00010000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    probe("R10", 8'h01, 32'h00030000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);

    // R12: overlapping large (idx0) and ordinary (idx1) entries
    do_reset();
    fill(8'h05, 20'h00000, 20'h00400, 1'b1, 1'b0, 1'b1);
    fill(8'h05, 20'h00003, 20'h77777, 1'b1, 1'b0, 1'b0);
    probe("R12", 8'h05, 32'h00003010, 1'b0, 1'b1, 1'b0, 32'h00403010, 1'b0);
    inval(8'h05, 20'h00200, 1'b0);
    probe("R12", 8'h05, 32'h00003010, 1'b0, 1'b1, 1'b0, 32'h77777010, 1'b0);

    // R6: free entries first, then round robin from entry 0
    do_reset();
    for (int i = 0; i < 16; i++) fill(8'h09, 20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b1, 1'b0, 1'b0);
    probe("R6", 8'h09, 32'h0010F00C, 1'b0, 1'b1, 1'b0, 32'h0020F00C, 1'b0);
    fill(8'h09, 20'h00300, 20'h00333, 1'b1, 1'b0, 1'b0);
    probe("R6", 8'h09, 32'h00100000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    probe("R6", 8'h09, 32'h00101000, 1'b0, 1'b1, 1'b0, 32'h00201000, 1'b0);
    probe("R6", 8'h09, 32'h00300abc, 1'b0, 1'b1, 1'b0, 32'h00333abc, 1'b0);
    fill(8'h09, 20'h00301, 20'h00334, 1'b1, 1'b0, 1'b0);
    probe("R6", 8'h09, 32'h00101000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    inval(8'h09, 20'h00105, 1'b0);
    fill(8'h09, 20'h00302, 20'h00335, 1'b1, 1'b0, 1'b0);
    probe("R6", 8'h09, 32'h00102000, 1'b0, 1'b1, 1'b0, 32'h00202000, 1'b0);
    fill(8'h09, 20'h00303, 20'h00336, 1'b1, 1'b0, 1'b0);
    probe("R6", 8'h09, 32'h00102000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    probe("R6", 8'h09, 32'h00302010, 1'b0, 1'b1, 1'b0, 32'h00335010, 1'b0);
    probe("R6", 8'h09, 32'h00103010, 1'b0, 1'b1, 1'b0, 32'h00203010, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule